// File: doc/BRIEF.md
# Indexed NVRAM Access Port

This block gives a processor access to a byte-wide non-volatile memory array through a four-byte I/O window. Software first loads a 16-bit pointer through two byte offsets, one for the low byte and one for the high byte. It then moves a byte through the data offset. After every data write the pointer returns to zero, so the next transfer has to load its address again. A data read leaves the pointer where it is.

Two fixed sixteen-byte windows in the array can be hidden from the port. The window at 0x20..0x2F is tied to guard bit 0 and the window at 0x30..0x3F to guard bit 1. A one-cycle flip request with a one-bit select inverts the chosen guard bit. While a guard bit is set, writes into its window are discarded and reads from it return 0xFF. Pointer values at or above the configured array size behave the same way. The array keeps its contents through reset. Reset only returns the pointer, both guard bits and the read register to their idle values.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 loads pointer bits 7:0 from the data byte and keeps pointer bits 15:8.
- R2: A write to offset 1 loads pointer bits 15:8 from the data byte and keeps pointer bits 7:0.
- R3: A write to offset 3 stores the data byte at the pointer address, if that address is accessible, and then sets the pointer to 0x0000. This happens even when the store itself is discarded.
- R4: A read of offset 3 places the byte at the pointer address on `rd_data` in the clock edge that samples the strobe. The pointer does not change.
- R5: A read of offset 0, 1 or 2 returns 0xFF. A write to offset 2 changes neither the pointer nor the array.
- R6: While guard bit 0 is set, addresses 0x20..0x2F are inaccessible. While guard bit 1 is set, addresses 0x30..0x3F are inaccessible. An inaccessible write is discarded and an inaccessible read returns 0xFF.
- R7: A cycle with `guard_flip` high inverts the guard bit chosen by `guard_sel`. A second flip restores the original access.
- R8: Addresses at or above `MEM_BYTES` are inaccessible: writes there are discarded and reads return 0xFF.
- R9: Reset sets the pointer to 0x0000, clears both guard bits and sets `rd_data` to 0xFF. Array contents survive reset.
- R10: `rd_data` changes only at a read strobe. It keeps its value across write strobes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| guard_flip | input | 1 | Invert the selected guard bit |
| guard_sel | input | 1 | Guard bit index for `guard_flip` |

## Verification
The hardest case to reach is a data write to a hidden address. The store must be discarded, yet the pointer must still return to zero. From the ports, that can only be seen indirectly: a later read at address 0 must return the byte stored there earlier, and a reread of the hidden byte after it is unhidden must return its old value. The random phase mostly draws pointers inside 0x00..0x7F, so both guard windows are hit often. It mixes guard flips with the accesses, and a quarter of the pointers fall beyond the array. A bench shadow model tracks which bytes have been written, and only those bytes are compared.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
    localparam int NVP_PTR_W       = 16;
    localparam int NVP_GUARDS      = 2;
    localparam int NVP_GUARD_SEL_W = 1;
    localparam int NVP_WIN_BASE    = 32;   // first hidden window at 0x20
    localparam int NVP_WIN_LOG2    = 4;    // sixteen bytes per window
    localparam logic [7:0] NVP_IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        OFS_PTR_LO = 2'd0,
        OFS_PTR_HI = 2'd1,
        OFS_SPARE  = 2'd2,
        OFS_DATA   = 2'd3
    } port_ofs_e;

    typedef struct packed {
        logic [NVP_PTR_W-1:0]  ptr;
        logic [NVP_GUARDS-1:0] guard;
        logic [7:0]            rdata;
    } port_state_t;
endpackage

// File: rtl/nvp_window_gate.sv
module nvp_window_gate #(
    parameter int PTR_W    = 16,
    parameter int BASE     = 32,
    parameter int WIN_LOG2 = 4
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic             guard_on,
    output logic             hidden
);
    localparam int TAG_W = PTR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(BASE >> WIN_LOG2);

    always_comb begin
        hidden = guard_on && (ptr[PTR_W-1:WIN_LOG2] == WIN_TAG);
    end
endmodule

// File: rtl/nvp_byte_store.sv
module nvp_byte_store #(
    parameter int DEPTH = 2048,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[idx] <= wr_byte;
        end
    end

    always_comb begin
        rd_byte = cells[idx];
    end
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [1:0]                 bus_off,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 rd_data,
    input  logic                       guard_flip,
    input  logic [NVP_GUARD_SEL_W-1:0] guard_sel
);
    port_state_t cur_q, cur_d;

    logic [NVP_GUARDS-1:0] hidden;
    logic                  in_range;
    logic                  reachable;
    logic                  store_we;
    logic [7:0]            store_rd;
    port_ofs_e             ofs;

    assign ofs = port_ofs_e'(bus_off);

    // One gate per hidden window; windows are laid out back to back.
    for (genvar g = 0; g < NVP_GUARDS; g++) begin : g_win
        nvp_window_gate #(
            .PTR_W   (NVP_PTR_W),
            .BASE    (NVP_WIN_BASE + g * (1 << NVP_WIN_LOG2)),
            .WIN_LOG2(NVP_WIN_LOG2)
        ) u_gate (
            .ptr     (cur_q.ptr),
            .guard_on(cur_q.guard[g]),
            .hidden  (hidden[g])
        );
    end

    always_comb begin
        in_range  = 32'(cur_q.ptr) < 32'(MEM_BYTES);
        reachable = in_range && !(|hidden);
    end

    nvp_byte_store #(.DEPTH(MEM_BYTES)) u_store (
        .clk    (clk),
        .wr_en  (store_we),
        .idx    (cur_q.ptr[IDX_W-1:0]),
        .wr_byte(bus_wdata),
        .rd_byte(store_rd)
    );

    always_comb begin
        cur_d    = cur_q;
        store_we = 1'b0;

        if (guard_flip) begin
            cur_d.guard[guard_sel] = ~cur_q.guard[guard_sel];
        end

        if (bus_sel && bus_we) begin
            unique case (ofs)
                OFS_PTR_LO: cur_d.ptr[7:0] = bus_wdata;
                OFS_PTR_HI: cur_d.ptr[NVP_PTR_W-1:8] = bus_wdata;
                OFS_DATA: begin
                    store_we  = reachable;
                    cur_d.ptr = '0;
                end
                default: ;
            endcase
        end

        if (bus_sel && !bus_we) begin
            cur_d.rdata = (ofs == OFS_DATA && reachable) ? store_rd : NVP_IDLE_BYTE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ptr   <= '0;
            cur_q.guard <= '0;
            cur_q.rdata <= NVP_IDLE_BYTE;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign rd_data = cur_q.rdata;
endmodule

// File: rtl/nvp_checker.sv
module nvp_checker
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 2048
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [1:0]                 bus_off,
    input logic [7:0]                 bus_wdata,
    input logic [7:0]                 rd_data,
    input logic                       guard_flip,
    input logic [NVP_GUARD_SEL_W-1:0] guard_sel,
    input logic [NVP_PTR_W-1:0]       ptr_q,
    input logic [NVP_GUARDS-1:0]      guard_q
);
    logic rd_strobe, wr_strobe;
    assign rd_strobe = bus_sel && !bus_we;
    assign wr_strobe = bus_sel && bus_we;

    p_ptr_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_off == 2'd0) |=>
            (ptr_q[7:0] == $past(bus_wdata) && ptr_q[15:8] == $past(ptr_q[15:8])));

    p_ptr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_off == 2'd1) |=>
            (ptr_q[15:8] == $past(bus_wdata) && ptr_q[7:0] == $past(ptr_q[7:0])));

    p_data_clears_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_off == 2'd3) |=> (ptr_q == '0));

    p_read_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && bus_off == 2'd3) |=> $stable(ptr_q));

    p_side_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && bus_off != 2'd3) |=> (rd_data == 8'hFF));

    p_spare_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_off == 2'd2) |=> $stable(ptr_q));

    p_hidden_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && bus_off == 2'd3 &&
         ((guard_q[0] && ptr_q[15:4] == 12'h002) || (guard_q[1] && ptr_q[15:4] == 12'h003)))
            |=> (rd_data == 8'hFF));

    p_guard_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        guard_flip |=> (guard_q[$past(guard_sel)] != $past(guard_q[guard_sel])));

    p_range_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && bus_off == 2'd3 && 32'(ptr_q) >= 32'(MEM_BYTES)) |=> (rd_data == 8'hFF));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));
endmodule

bind nvram_index_port nvp_checker #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .guard_flip(guard_flip),
    .guard_sel (guard_sel),
    .ptr_q     (cur_q.ptr),
    .guard_q   (cur_q.guard)
);

// File: tb/nvram_index_port_bench.sv
`timescale 1ns/1ps
module nvram_index_port_bench;
    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_off = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] rd_data;
    logic       guard_flip = 1'b0;
    logic [0:0] guard_sel = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    // shadow model
    logic [7:0]  m_mem [MEM];
    bit          m_ok  [MEM];
    logic [15:0] m_ptr = 16'd0;
    logic [1:0]  m_guard = 2'b00;

    always #4 clk = ~clk;

    nvram_index_port #(.MEM_BYTES(MEM)) u_nvram_index_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .guard_flip(guard_flip), .guard_sel(guard_sel)
    );

    function automatic bit m_reach(input logic [15:0] a);
        if (32'(a) >= MEM) return 1'b0;
        if (m_guard[0] && a[15:4] == 12'h002) return 1'b0;
        if (m_guard[1] && a[15:4] == 12'h003) return 1'b0;
        return 1'b1;
    endfunction

    // -1 when the expected byte is unknown (never written)
    function automatic int m_expect(input logic [15:0] a);
        if (!m_reach(a)) return 32'hFF;
        if (!m_ok[a[10:0]]) return -1;
        return int'(m_mem[a[10:0]]);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        case (off)
            2'd0: m_ptr[7:0] = d;
            2'd1: m_ptr[15:8] = d;
            2'd3: begin
                if (m_reach(m_ptr)) begin
                    m_mem[m_ptr[10:0]] = d;
                    m_ok[m_ptr[10:0]] = 1'b1;
                end
                m_ptr = 16'd0;
            end
            default: ;
        endcase
    endtask

    task automatic bus_rd(input logic [1:0] off, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_off = off;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        bus_wr(2'd0, a[7:0]);
        bus_wr(2'd1, a[15:8]);
    endtask

    task automatic flip(input bit s);
        @(negedge clk);
        guard_flip = 1'b1; guard_sel = s;
        @(negedge clk);
        guard_flip = 1'b0;
        m_guard[s] = ~m_guard[s];
    endtask

    task automatic rd_check(input string req);
        logic [7:0] v;
        int e;
        e = m_expect(m_ptr);
        bus_rd(2'd3, v);
        if (e >= 0) check(req, v, 8'(e));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        @(negedge clk);
        check("R9 rd_data after reset", rd_data, 8'hFF);
        bus_wr(2'd3, 8'h5A);                 // pointer is 0 after reset
        rd_check("R9 pointer zero after reset");

        // R1/R2: pointer byte loads
        set_ptr(16'h0123);
        bus_wr(2'd3, 8'hC3);
        set_ptr(16'h0100);
        bus_wr(2'd0, 8'h23);                 // high byte kept at 01
        rd_check("R1 low byte load keeps high");
        set_ptr(16'h0223);
        bus_wr(2'd1, 8'h01);                 // low byte kept at 23
        rd_check("R2 high byte load keeps low");

        // R4: read keeps pointer
        rd_check("R4 repeated read same pointer");

        // R3: data write clears pointer
        bus_wr(2'd3, 8'h77);
        rd_check("R3 pointer cleared after data write");
        set_ptr(16'h0123);
        rd_check("R3 stored byte");

        // R5: side offsets and spare write
        bus_rd(2'd0, v); check("R5 read offset 0", v, 8'hFF);
        bus_rd(2'd1, v); check("R5 read offset 1", v, 8'hFF);
        bus_rd(2'd2, v); check("R5 read offset 2", v, 8'hFF);
        bus_wr(2'd2, 8'h00);
        rd_check("R5 spare write ignored");

        // R10: rd_data holds across writes and idle
        bus_rd(2'd3, v);
        bus_wr(2'd2, 8'h11);
        repeat (3) @(negedge clk);
        check("R10 rd_data held", rd_data, v);

        // R6/R7: hidden windows
        set_ptr(16'h0025); bus_wr(2'd3, 8'hA5);
        set_ptr(16'h0035); bus_wr(2'd3, 8'hB6);
        flip(1'b0);
        set_ptr(16'h0025); rd_check("R6 window 0 read hidden");
        bus_wr(2'd3, 8'h00);                 // dropped, pointer still cleared
        rd_check("R3 pointer cleared on hidden write");
        set_ptr(16'h0035); rd_check("R6 window 1 open");
        flip(1'b1);
        set_ptr(16'h0035); rd_check("R6 window 1 read hidden");
        flip(1'b0);
        set_ptr(16'h0025); rd_check("R7 second flip restores window 0");
        set_ptr(16'h001F); bus_wr(2'd3, 8'h1F);
        set_ptr(16'h001F); rd_check("R6 edge below window open");

        // R8: beyond array
        set_ptr(16'(MEM)); bus_wr(2'd3, 8'h99);
        set_ptr(16'(MEM)); rd_check("R8 first address past end");
        set_ptr(16'hFFFF); rd_check("R8 top address");
        set_ptr(16'(MEM - 1)); bus_wr(2'd3, 8'h3C);
        set_ptr(16'(MEM - 1)); rd_check("R8 last valid address");

        // R9: reset clears guards, keeps array
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_guard = 2'b00; m_ptr = 16'd0;
        check("R9 rd_data after second reset", rd_data, 8'hFF);
        set_ptr(16'h0035); rd_check("R9 guard cleared, array kept");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3) begin
                logic [15:0] a;
                int k;
                k = int'($urandom_range(0, 3));
                if (k == 0) a = 16'($urandom);
                else a = 16'($urandom_range(0, 127));
                set_ptr(a);
            end else if (op < 5) begin
                bus_wr(2'd3, 8'($urandom));
            end else if (op < 8) begin
                rd_check("R4/R6/R8 random read");
            end else if (op == 8) begin
                flip(1'($urandom));
            end else begin
                logic [1:0] o;
                o = 2'($urandom_range(0, 2));
                bus_rd(o, v);
                check("R5 random side read", v, 8'hFF);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule